// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This block forms the data address of a memory operand for a register-memory machine with eight 32-bit general purpose registers. Each cycle it can take one request. A request carries an addressing mode, a base register number, an index register number, a 2-bit scale, and a displacement with its size. The current register file contents arrive alongside the request as one flat vector. One clock later the block returns the address, or it raises a flag when the request combines registers in a way the machine forbids.

Four modes are provided:
- register indirect;
- base plus displacement;
- base plus scaled index;
- base plus scaled index plus displacement.

The index is multiplied by 1, 2, 4 or 8 before the add. A short displacement is sign-extended before it is used. All sums wrap modulo 2^32. Register 4 (stack pointer) and register 5 (frame pointer) are refused as the base in the two non-indexed modes. Register 4 is refused as the index in every indexed mode. When a request is refused, the address output reads zero.

Top module: `ea_agu`

## Requirements
- R1: After reset, `ea_valid`, `ea_illegal` and `ea_addr` are all 0.
- R2: `ea_valid` equals the `req_valid` of the previous cycle. A cycle without `req_valid` leaves `ea_addr` and `ea_illegal` unchanged.
- R3: Register indirect (`mode` = 0) returns the base register value one cycle later. The displacement inputs have no effect in this mode.
- R4: Base plus displacement (`mode` = 1) adds the displacement to the base register. For `disp_kind` = 1 the displacement is `disp_val[7:0]` sign-extended to 32 bits. For `disp_kind` = 2 it is the full `disp_val`.
- R5: Scaled index (`mode` = 2) returns base + index × 2^`scale`, with `scale` 0..3 meaning ×1, ×2, ×4, ×8. The displacement inputs have no effect in this mode.
- R6: Scaled index with displacement (`mode` = 3) returns base + index × 2^`scale` + displacement, with the displacement formed as in R4.
- R7: Every address sum wraps modulo 2^32.
- R8: In modes 0 and 1, a base of register 4 or 5 sets `ea_illegal`. In modes 2 and 3, either register is accepted as the base.
- R9: In modes 2 and 3, an index of register 4 sets `ea_illegal`. Register 5 is accepted as the index.
- R10: In modes 1 and 3, a `disp_kind` of 0 (none) or 3 (reserved) sets `ea_illegal`. Modes 0 and 2 ignore `disp_kind`.
- R11: Whenever `ea_illegal` is 1, `ea_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| mode | input | 2 | 0 indirect, 1 base+disp, 2 scaled, 3 scaled+disp |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| scale | input | 2 | Index multiplier exponent |
| disp_kind | input | 2 | 0 none, 1 short (8-bit), 2 full (32-bit), 3 reserved |
| disp_val | input | 32 | Displacement; short form uses bits 7:0 |
| gpr_flat | input | 256 | Register file contents; register n occupies bits 32n+31:32n |
| ea_valid | output | 1 | Result presented this cycle |
| ea_addr | output | 32 | Effective address, 0 when illegal |
| ea_illegal | output | 1 | Forbidden register or displacement combination |

## Verification
Register indirect is driven with nonzero displacement fields, which exposes any leak of the displacement into that mode. A short displacement of 0x80 and above is contrasted with a full one, which separates correct sign extension from zero extension. The scaled modes are tried with every scale code and with index values whose top bits fall off, so a wrong shift amount or a missing wrap becomes visible. Each banned register is placed in the allowed role and in the forbidden role, under every mode. Several hundred further cycles with random fields and random idle gaps check latency and hold against the bench's own model.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [1:0] {
      EA_INDIRECT    = 2'd0,
      EA_BASE_DISP   = 2'd1,
      EA_SCALED      = 2'd2,
      EA_SCALED_DISP = 2'd3
   } ea_mode_e;

   typedef enum logic [1:0] {
      DSP_NONE  = 2'd0,
      DSP_SHORT = 2'd1,
      DSP_FULL  = 2'd2,
      DSP_RSVD  = 2'd3
   } dsp_kind_e;

   function automatic logic mode_has_index(input ea_mode_e m);
      return (m == EA_SCALED) || (m == EA_SCALED_DISP);
   endfunction

   function automatic logic mode_has_disp(input ea_mode_e m);
      return (m == EA_BASE_DISP) || (m == EA_SCALED_DISP);
   endfunction

endpackage

// File: rtl/ea_reg_pick.sv
module ea_reg_pick #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 8,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   input  logic [SEL_W-1:0]           sel,
   output logic [DATA_W-1:0]          value
);

   logic [DATA_W-1:0] slot [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      assign slot[g] = regs_flat[g*DATA_W +: DATA_W];
   end

   assign value = slot[sel];

endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
   import ea_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SHORT_DISP_W = 8
) (
   input  logic [1:0]        kind,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] ext,
   output logic              kind_ok
);

   localparam int PAD_W = DATA_W - SHORT_DISP_W;

   dsp_kind_e         k;
   logic [DATA_W-1:0] short_ext;

   assign k         = dsp_kind_e'(kind);
   assign short_ext = {{PAD_W{raw[SHORT_DISP_W-1]}}, raw[SHORT_DISP_W-1:0]};

   always_comb begin
      ext     = '0;
      kind_ok = 1'b0;
      unique case (k)
         DSP_SHORT: begin ext = short_ext; kind_ok = 1'b1; end
         DSP_FULL:  begin ext = raw;       kind_ok = 1'b1; end
         default:   begin ext = '0;        kind_ok = 1'b0; end
      endcase
   end

endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
   parameter int DATA_W       = 32,
   parameter int SCALE_W      = 2,
   parameter bit MUX_VARIANT  = 1'b0
) (
   input  logic [DATA_W-1:0]  value,
   input  logic [SCALE_W-1:0] amt,
   output logic [DATA_W-1:0]  scaled
);

   localparam int N_STEPS = 1 << SCALE_W;

   if (MUX_VARIANT) begin : g_mux
      logic [DATA_W-1:0] cand [N_STEPS];
      for (genvar g = 0; g < N_STEPS; g++) begin : g_cand
         assign cand[g] = value << g;
      end
      assign scaled = cand[amt];
   end else begin : g_shift
      assign scaled = value << amt;
   end

endmodule

// File: rtl/ea_rule_check.sv
module ea_rule_check
   import ea_pkg::*;
#(
   parameter int SEL_W  = 3,
   parameter int SP_IDX = 4,
   parameter int FP_IDX = 5
) (
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] base_sel,
   input  logic [SEL_W-1:0] index_sel,
   input  logic             kind_ok,
   output logic             illegal
);

   localparam logic [SEL_W-1:0] SP_CODE = SEL_W'(SP_IDX);
   localparam logic [SEL_W-1:0] FP_CODE = SEL_W'(FP_IDX);

   ea_mode_e m;
   logic     base_bad, index_bad, disp_bad;

   assign m = ea_mode_e'(mode);

   always_comb begin
      base_bad  = !mode_has_index(m) && (base_sel == SP_CODE || base_sel == FP_CODE);
      index_bad = mode_has_index(m) && (index_sel == SP_CODE);
      disp_bad  = mode_has_disp(m) && !kind_ok;
      illegal   = base_bad | index_bad | disp_bad;
   end

endmodule

// File: rtl/ea_agu.sv
module ea_agu
   import ea_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int NUM_REGS     = 8,
   parameter int SCALE_W      = 2,
   parameter int SHORT_DISP_W = 8,
   parameter int SP_IDX       = 4,
   parameter int FP_IDX       = 5,
   parameter bit MUX_SCALER   = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [1:0]                  mode,
   input  logic [$clog2(NUM_REGS)-1:0] base_sel,
   input  logic [$clog2(NUM_REGS)-1:0] index_sel,
   input  logic [SCALE_W-1:0]          scale,
   input  logic [1:0]                  disp_kind,
   input  logic [DATA_W-1:0]           disp_val,
   input  logic [NUM_REGS*DATA_W-1:0]  gpr_flat,
   output logic                        ea_valid,
   output logic [DATA_W-1:0]           ea_addr,
   output logic                        ea_illegal
);

   localparam int SEL_W = $clog2(NUM_REGS);

   if (SP_IDX >= NUM_REGS || FP_IDX >= NUM_REGS) begin : g_bad_idx
      $error("ea_agu: stack/frame register number outside the register file");
   end
   if (SHORT_DISP_W >= DATA_W || SHORT_DISP_W < 1) begin : g_bad_disp
      $error("ea_agu: short displacement width must be below the data width");
   end
   if ((1 << SCALE_W) > DATA_W) begin : g_bad_scale
      $error("ea_agu: scale range exceeds the data width");
   end

   logic [DATA_W-1:0] base_val, index_val, index_scaled, disp_ext;
   logic [DATA_W-1:0] idx_term, disp_term, sum;
   logic              kind_ok, illegal;
   ea_mode_e          m;

   assign m = ea_mode_e'(mode);

   ea_reg_pick #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_base_pick (
      .regs_flat (gpr_flat),
      .sel       (base_sel),
      .value     (base_val)
   );

   ea_reg_pick #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_index_pick (
      .regs_flat (gpr_flat),
      .sel       (index_sel),
      .value     (index_val)
   );

   ea_scaler #(.DATA_W(DATA_W), .SCALE_W(SCALE_W), .MUX_VARIANT(MUX_SCALER)) u_scaler (
      .value  (index_val),
      .amt    (scale),
      .scaled (index_scaled)
   );

   ea_disp_ext #(.DATA_W(DATA_W), .SHORT_DISP_W(SHORT_DISP_W)) u_disp (
      .kind    (disp_kind),
      .raw     (disp_val),
      .ext     (disp_ext),
      .kind_ok (kind_ok)
   );

   ea_rule_check #(.SEL_W(SEL_W), .SP_IDX(SP_IDX), .FP_IDX(FP_IDX)) u_rules (
      .mode      (mode),
      .base_sel  (base_sel),
      .index_sel (index_sel),
      .kind_ok   (kind_ok),
      .illegal   (illegal)
   );

   always_comb begin
      idx_term  = mode_has_index(m) ? index_scaled : '0;
      disp_term = mode_has_disp(m)  ? disp_ext     : '0;
      sum       = base_val + idx_term + disp_term;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_valid   <= 1'b0;
         ea_illegal <= 1'b0;
         ea_addr    <= '0;
      end else begin
         ea_valid <= req_valid;
         if (req_valid) begin
            ea_illegal <= illegal;
            ea_addr    <= illegal ? '0 : sum;
         end
      end
   end

endmodule

// File: rtl/ea_agu_checker.sv
module ea_agu_checker #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 8,
   parameter int SCALE_W  = 2,
   parameter int SP_IDX   = 4,
   parameter int FP_IDX   = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic [1:0]                  mode,
   input logic [$clog2(NUM_REGS)-1:0] base_sel,
   input logic [$clog2(NUM_REGS)-1:0] index_sel,
   input logic [SCALE_W-1:0]          scale,
   input logic [1:0]                  disp_kind,
   input logic [DATA_W-1:0]           disp_val,
   input logic [NUM_REGS*DATA_W-1:0]  gpr_flat,
   input logic                        ea_valid,
   input logic [DATA_W-1:0]           ea_addr,
   input logic                        ea_illegal
);

   localparam int SEL_W = $clog2(NUM_REGS);
   localparam logic [SEL_W-1:0] SP_C = SEL_W'(SP_IDX);
   localparam logic [SEL_W-1:0] FP_C = SEL_W'(FP_IDX);

   logic started;
   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ea_valid == $past(req_valid));

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !req_valid) |=> ($stable(ea_addr) && $stable(ea_illegal)));

   p_indirect_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && mode == 2'd0 && base_sel != SP_C && base_sel != FP_C)
      |=> ea_addr == $past(gpr_flat[base_sel*DATA_W +: DATA_W]));

   p_full_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && mode == 2'd1 && disp_kind == 2'd2 &&
       base_sel != SP_C && base_sel != FP_C)
      |=> ea_addr == $past(gpr_flat[base_sel*DATA_W +: DATA_W] + disp_val));

   p_scaled_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && mode == 2'd2 && index_sel != SP_C)
      |=> ea_addr == $past(gpr_flat[base_sel*DATA_W +: DATA_W] +
                           (gpr_flat[index_sel*DATA_W +: DATA_W] << scale)));

   p_base_ban_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && !mode[1] && (base_sel == SP_C || base_sel == FP_C))
      |=> ea_illegal);

   p_index_ban_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && mode[1] && index_sel == SP_C) |=> ea_illegal);

   p_disp_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (started && req_valid && mode[0] && (disp_kind == 2'd0 || disp_kind == 2'd3))
      |=> ea_illegal);

   p_zero_on_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ea_illegal |-> ea_addr == '0);

endmodule

bind ea_agu ea_agu_checker #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .SCALE_W  (SCALE_W),
   .SP_IDX   (SP_IDX),
   .FP_IDX   (FP_IDX)
) u_ea_agu_checker (.*);

// File: tb/ea_agu_bench.sv
`timescale 1ns/1ps
module ea_agu_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req_valid;
   logic [1:0]   mode;
   logic [2:0]   base_sel, index_sel;
   logic [1:0]   scale, disp_kind;
   logic [31:0]  disp_val;
   logic [255:0] gpr_flat;
   logic         ea_valid, ea_illegal;
   logic [31:0]  ea_addr;

   logic [31:0] regs [8];

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic        exp_valid = 1'b0, exp_ill = 1'b0;
   logic [31:0] exp_addr  = '0;
   string       exp_tag   = "R1";

   always #2.5 clk = ~clk;

   ea_agu u_ea_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .base_sel(base_sel), .index_sel(index_sel), .scale(scale),
      .disp_kind(disp_kind), .disp_val(disp_val), .gpr_flat(gpr_flat),
      .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_illegal(ea_illegal)
   );

   function automatic logic [255:0] pack_regs();
      logic [255:0] f;
      for (int i = 0; i < 8; i++) f[i*32 +: 32] = regs[i];
      return f;
   endfunction

   task automatic check_now();
      n_checks++;
      if (ea_valid !== exp_valid || ea_illegal !== exp_ill || ea_addr !== exp_addr) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b ill=%0b addr=%h, expected valid=%0b ill=%0b addr=%h",
                  exp_tag, ea_valid, ea_illegal, ea_addr, exp_valid, exp_ill, exp_addr);
      end
   endtask

   // Drive one cycle at the falling edge: compare what the previous request
   // produced, then present the new one and predict its result.
   task automatic step(input bit rq, input int md, input int b, input int ix,
                       input int sc, input int kd, input logic [31:0] dv, input string tag);
      longint unsigned acc;
      longint signed   dext;
      bit ill;
      @(negedge clk);
      check_now();
      req_valid = rq; mode = md[1:0]; base_sel = b[2:0]; index_sel = ix[2:0];
      scale = sc[1:0]; disp_kind = kd[1:0]; disp_val = dv; gpr_flat = pack_regs();
      exp_valid = rq;
      if (rq) begin
         ill = 1'b0;
         if (md < 2 && (b == 4 || b == 5)) ill = 1'b1;
         if (md >= 2 && ix == 4) ill = 1'b1;
         if ((md % 2) == 1 && !(kd == 1 || kd == 2)) ill = 1'b1;
         dext = (kd == 1) ? longint'($signed(dv[7:0])) : longint'(dv);
         acc = longint'(regs[b]);
         if (md >= 2) acc = acc + longint'(regs[ix]) * (64'd1 << sc);
         if ((md % 2) == 1) acc = acc + dext;
         exp_ill  = ill;
         exp_addr = ill ? 32'd0 : acc[31:0];
         exp_tag  = tag;
      end else begin
         exp_tag = "R2 hold";
      end
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; mode = '0; base_sel = '0; index_sel = '0;
      scale = '0; disp_kind = '0; disp_val = '0;
      for (int i = 0; i < 8; i++) regs[i] = 32'h1000_0000 * i + 32'h111 * (i + 1);
      gpr_flat = pack_regs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_now(); // R1 reset state
      rst_n = 1'b1;

      step(1, 0, 3, 6, 3, 2, 32'hDEAD_BEEF, "R3 indirect, disp ignored");
      step(1, 1, 2, 0, 0, 1, 32'h0000_0080, "R4 short disp negative");
      step(1, 1, 2, 0, 0, 1, 32'hFFFF_FF7F, "R4 short disp positive");
      step(1, 1, 1, 0, 0, 2, 32'h0000_0080, "R4 full disp");
      for (int s = 0; s < 4; s++) step(1, 2, 0, 7, s, 3, 32'h5, "R5 scaled");
      step(1, 3, 6, 2, 2, 1, 32'h0000_00F0, "R6 scaled short disp");
      step(1, 3, 6, 2, 3, 2, 32'h0123_4567, "R6 scaled full disp");
      regs[1] = 32'hFFFF_FFF0; regs[7] = 32'hF000_0001;
      step(1, 1, 1, 0, 0, 1, 32'h0000_0020, "R7 wrap disp");
      step(1, 3, 1, 7, 3, 2, 32'h8000_0000, "R7 wrap scaled");
      step(1, 0, 4, 0, 0, 0, 32'h0, "R8 R11 sp base indirect");
      step(1, 1, 5, 0, 0, 2, 32'h40, "R8 R11 fp base disp");
      step(1, 2, 4, 1, 1, 0, 32'h0, "R8 sp base ok scaled");
      step(1, 3, 5, 1, 0, 1, 32'h8, "R8 fp base ok scaled disp");
      step(1, 2, 0, 4, 2, 0, 32'h0, "R9 R11 sp index");
      step(1, 2, 0, 5, 2, 0, 32'h0, "R9 fp index ok");
      step(1, 1, 0, 0, 0, 0, 32'h10, "R10 R11 no disp kind");
      step(1, 3, 0, 1, 0, 3, 32'h10, "R10 R11 reserved kind");
      step(1, 2, 0, 1, 0, 3, 32'h10, "R10 kind ignored scaled");
      step(0, 1, 4, 4, 0, 0, 32'h0, "R2");
      step(0, 3, 0, 4, 0, 3, 32'h0, "R2");
      step(1, 0, 2, 0, 0, 0, 32'h0, "R3");
      step(0, 0, 5, 0, 0, 0, 32'h0, "R2");

      for (int n = 0; n < 400; n++) begin
         int md, kd;
         md = int'($urandom_range(0, 3));
         kd = int'($urandom_range(0, 3));
         if (n % 50 == 0)
            for (int i = 0; i < 8; i++) regs[i] = $urandom();
         step(($urandom_range(0, 4) != 0), md, int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), kd, $urandom(),
              md == 0 ? "R3 random" : md == 1 ? "R4 random" : md == 2 ? "R5 random" : "R6 random");
      end
      step(0, 0, 0, 0, 0, 0, 32'h0, "R2");
      @(negedge clk);
      check_now();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule